// File: doc/BRIEF.md
# Chip-Addressed Global Configuration Register File

This block holds the chip-wide configuration words of a front-end readout die. It takes commands whose fields have already been decoded: a command kind, a 3-bit chip address, a 6-bit register address and, for writes, a 16-bit data word. Slow commands (register write and register read) act only when their chip address equals the 3-bit identity set by strap inputs. Fast and trigger commands are passed on whatever chip address they carry.

The 64-word address space has two parts. Locations 0 to 35 are held in flops. They can be written and read, and every stored word drives a flat output bus toward the consumers of the configuration. Locations 36 to 63 can only be read, and they return words taken from a status input bus. Some writable locations take their incoming word in reversed bit order, as a build-time map selects. A write that is refused raises a one-cycle reject pulse. A read answers one clock after it is taken.

Top module: `gcr_cfg_top`

## Requirements
- R1: A slow command (kind 2'b00 write, 2'b01 read) acts only when `cmd_chip` equals `strap_id`. With all straps open (`strap_id` = 3'b000), chip address 3'b000 is served.
- R2: An accepted write to an address from 0 to 35 stores `cmd_data` at that location. A later read of that location returns the stored word.
- R3: A writable location whose bit in `ORDER_MAP` is 1 stores the word bit-reversed: data bit k goes to stored bit 15-k. Other locations store the word unchanged. The default map sets bits 1, 3, 8, 9, 10, 11 and 35.
- R4: A write to an address from 36 to 63 changes no stored word. It raises `wr_reject` high for exactly the one cycle after the command edge.
- R5: A write whose chip address does not match changes no stored word and raises `wr_reject` for one cycle. A read whose chip address does not match gives no `rd_valid`.
- R6: After an accepted read, `rd_valid` is high for the one cycle that follows the command edge, and `rd_data` carries the word. For addresses 36 to 63 the word is `status_bus[(addr-36)*16 +: 16]`.
- R7: A fast command (kind 2'b10) pulses `fast_go` and a trigger command (kind 2'b11) pulses `trig_go`, one cycle after the command edge, for any chip address.
- R8: Synchronous reset loads location i with 16'hC300 ^ (i << 2) and clears `rd_valid`, `wr_reject`, `fast_go` and `trig_go`.
- R9: `cfg_flat[i*16 +: 16]` always shows the word stored at writable location i. An accepted write makes the new word visible one cycle after the command edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_id | input | 3 | Chip identity from strap pins, 000 when open |
| cmd_valid | input | 1 | Command fields are valid this cycle |
| cmd_kind | input | 2 | 00 write, 01 read, 10 fast, 11 trigger |
| cmd_chip | input | 3 | Chip address carried by the command |
| cmd_addr | input | 6 | Register address |
| cmd_data | input | 16 | Write data |
| status_bus | input | 448 | Read-only words for addresses 36 to 63, 16 bits each |
| cfg_flat | output | 576 | Stored configuration words, location i at bits i*16 |
| rd_valid | output | 1 | Read answer strobe |
| rd_data | output | 16 | Read answer word |
| wr_reject | output | 1 | One-cycle pulse for a refused write |
| fast_go | output | 1 | Fast command passed on |
| trig_go | output | 1 | Trigger command passed on |

## Verification
The assertions assume that the command fields hold their values for the whole cycle in which `cmd_valid` is high. They also assume that the strap identity and the command inputs are quiet during reset. The assertions look one cycle back at those inputs, so a command held across the reset release would break them. The bench drives every command between falling edges and holds `cmd_valid` low while reset is high. It changes the straps only while no command is outstanding.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int GCR_AW      = 6;
  localparam int GCR_DW      = 16;
  localparam int GCR_IDW     = 3;
  localparam int GCR_WR_LAST = 35;

  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_READ  = 2'b01,
    CMD_FAST  = 2'b10,
    CMD_TRIG  = 2'b11
  } cmd_kind_e;

  // Value a writable location takes at reset.
  function automatic logic [GCR_DW-1:0] reset_word(input int unsigned idx);
    logic [GCR_DW-1:0] base;
    base = 16'hC300;
    return base ^ GCR_DW'(idx << 2);
  endfunction

  // Reverse the bit order of one word.
  function automatic logic [GCR_DW-1:0] flip_word(input logic [GCR_DW-1:0] w);
    logic [GCR_DW-1:0] r;
    for (int k = 0; k < GCR_DW; k++) r[GCR_DW-1-k] = w[k];
    return r;
  endfunction
endpackage

// File: rtl/gcr_cmd_filter.sv
module gcr_cmd_filter
  import gcr_pkg::*;
#(
  parameter int ADDR_W  = GCR_AW,
  parameter int ID_W    = GCR_IDW,
  parameter int WR_LAST = GCR_WR_LAST
) (
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ID_W-1:0]   cmd_chip,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ID_W-1:0]   strap_id,
  output logic              wr_hit,
  output logic              wr_bad,
  output logic              rd_hit,
  output logic              fast_hit,
  output logic              trig_hit
);
  logic id_match;
  logic in_wr_range;
  logic is_wr;
  logic is_rd;

  always_comb begin
    id_match    = (cmd_chip == strap_id);
    in_wr_range = (cmd_addr <= ADDR_W'(WR_LAST));
    is_wr       = cmd_valid && (cmd_kind == CMD_WRITE);
    is_rd       = cmd_valid && (cmd_kind == CMD_READ);
    wr_hit      = is_wr && id_match && in_wr_range;
    wr_bad      = is_wr && !(id_match && in_wr_range);
    rd_hit      = is_rd && id_match;
    fast_hit    = cmd_valid && (cmd_kind == CMD_FAST);
    trig_hit    = cmd_valid && (cmd_kind == CMD_TRIG);
  end
endmodule

// File: rtl/gcr_store.sv
module gcr_store
  import gcr_pkg::*;
#(
  parameter int              ADDR_W    = GCR_AW,
  parameter int              DATA_W    = GCR_DW,
  parameter int              NUM_WR    = GCR_WR_LAST + 1,
  parameter logic [NUM_WR-1:0] ORDER_MAP = 36'h8_0000_0F0A
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_hit,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_WR*DATA_W-1:0] cfg_flat
);
  logic [DATA_W-1:0] flipped;

  always_comb flipped = flip_word(wr_data);

  for (genvar i = 0; i < NUM_WR; i++) begin : g_loc
    logic [DATA_W-1:0] word_q;
    logic              sel;

    always_comb sel = wr_hit && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= reset_word(i);
      end else if (sel) begin
        if (ORDER_MAP[i]) word_q <= flipped;
        else              word_q <= wr_data;
      end
    end

    assign cfg_flat[i*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/gcr_readout.sv
module gcr_readout
  import gcr_pkg::*;
#(
  parameter int ADDR_W = GCR_AW,
  parameter int DATA_W = GCR_DW,
  parameter int NUM_WR = GCR_WR_LAST + 1,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int NUM_RO = DEPTH - NUM_WR
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_hit,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_WR*DATA_W-1:0] cfg_flat,
  input  logic [NUM_RO*DATA_W-1:0] status_bus,
  input  logic                     wr_bad,
  input  logic                     fast_hit,
  input  logic                     trig_hit,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     wr_reject,
  output logic                     fast_go,
  output logic                     trig_go
);
  logic [DATA_W-1:0] space [DEPTH];
  logic [DATA_W-1:0] rd_next;

  for (genvar i = 0; i < DEPTH; i++) begin : g_space
    if (i < NUM_WR) begin : g_wr
      assign space[i] = cfg_flat[i*DATA_W +: DATA_W];
    end else begin : g_ro
      assign space[i] = status_bus[(i-NUM_WR)*DATA_W +: DATA_W];
    end
  end

  always_comb rd_next = space[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      wr_reject <= 1'b0;
      fast_go   <= 1'b0;
      trig_go   <= 1'b0;
    end else begin
      rd_valid  <= rd_hit;
      if (rd_hit) rd_data <= rd_next;
      wr_reject <= wr_bad;
      fast_go   <= fast_hit;
      trig_go   <= trig_hit;
    end
  end
endmodule

// File: rtl/gcr_cfg_top.sv
module gcr_cfg_top
  import gcr_pkg::*;
#(
  parameter int ADDR_W  = GCR_AW,
  parameter int DATA_W  = GCR_DW,
  parameter int ID_W    = GCR_IDW,
  parameter int WR_LAST = GCR_WR_LAST,
  parameter logic [WR_LAST:0] ORDER_MAP = 36'h8_0000_0F0A,
  localparam int NUM_WR = WR_LAST + 1,
  localparam int NUM_RO = (1 << ADDR_W) - NUM_WR
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ID_W-1:0]          strap_id,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_kind,
  input  logic [ID_W-1:0]          cmd_chip,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [DATA_W-1:0]        cmd_data,
  input  logic [NUM_RO*DATA_W-1:0] status_bus,
  output logic [NUM_WR*DATA_W-1:0] cfg_flat,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     wr_reject,
  output logic                     fast_go,
  output logic                     trig_go
);
  logic wr_hit;
  logic wr_bad;
  logic rd_hit;
  logic fast_hit;
  logic trig_hit;

  gcr_cmd_filter #(.ADDR_W(ADDR_W), .ID_W(ID_W), .WR_LAST(WR_LAST)) u_filter (
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_chip  (cmd_chip),
    .cmd_addr  (cmd_addr),
    .strap_id  (strap_id),
    .wr_hit    (wr_hit),
    .wr_bad    (wr_bad),
    .rd_hit    (rd_hit),
    .fast_hit  (fast_hit),
    .trig_hit  (trig_hit)
  );

  gcr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WR(NUM_WR),
              .ORDER_MAP(ORDER_MAP)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .wr_addr  (cmd_addr),
    .wr_data  (cmd_data),
    .cfg_flat (cfg_flat)
  );

  gcr_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WR(NUM_WR)) u_readout (
    .clk        (clk),
    .rst        (rst),
    .rd_hit     (rd_hit),
    .rd_addr    (cmd_addr),
    .cfg_flat   (cfg_flat),
    .status_bus (status_bus),
    .wr_bad     (wr_bad),
    .fast_hit   (fast_hit),
    .trig_hit   (trig_hit),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .wr_reject  (wr_reject),
    .fast_go    (fast_go),
    .trig_go    (trig_go)
  );
endmodule

// File: rtl/gcr_cfg_chk.sv
module gcr_cfg_chk #(
  parameter int ADDR_W  = 6,
  parameter int ID_W    = 3,
  parameter int WR_LAST = 35,
  parameter int CFG_W   = 576
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   strap_id,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [ID_W-1:0]   cmd_chip,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CFG_W-1:0]  cfg_flat,
  input logic              rd_valid,
  input logic              wr_reject,
  input logic              fast_go,
  input logic              trig_go,
  input logic              wr_hit,
  input logic              wr_bad
);
  // R4
  refused_write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'b00 && cmd_addr > ADDR_W'(WR_LAST)) |=> wr_reject);

  // R5
  foreign_write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'b00 && cmd_chip != strap_id) |=> wr_reject);

  // R5
  foreign_read_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'b01 && cmd_chip != strap_id) |=> !rd_valid);

  // R6
  read_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'b01 && cmd_chip == strap_id) |=> rd_valid);

  // R9
  store_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(cfg_flat));

  // R1
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_hit, wr_bad}));

  // R7
  fast_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'b10) |=> fast_go);

  // R7
  trig_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'b11) |=> trig_go);
endmodule

bind gcr_cfg_top gcr_cfg_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .WR_LAST(WR_LAST), .CFG_W(NUM_WR*DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strap_id  (strap_id),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .cmd_chip  (cmd_chip),
  .cmd_addr  (cmd_addr),
  .cfg_flat  (cfg_flat),
  .rd_valid  (rd_valid),
  .wr_reject (wr_reject),
  .fast_go   (fast_go),
  .trig_go   (trig_go),
  .wr_hit    (wr_hit),
  .wr_bad    (wr_bad)
);

// File: tb/gcr_cfg_top_bench.sv
module gcr_cfg_top_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   strap_id = 3'b000;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_kind = 2'b00;
  logic [2:0]   cmd_chip = 3'b000;
  logic [5:0]   cmd_addr = '0;
  logic [15:0]  cmd_data = '0;
  logic [447:0] status_bus;
  logic [575:0] cfg_flat;
  logic         rd_valid;
  logic [15:0]  rd_data;
  logic         wr_reject;
  logic         fast_go;
  logic         trig_go;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  always_comb
    for (int j = 0; j < 28; j++) status_bus[j*16 +: 16] = 16'hE000 | 16'(j);

  gcr_cfg_top u_gcr_cfg_top (
    .clk(clk), .rst(rst), .strap_id(strap_id), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_chip(cmd_chip), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .status_bus(status_bus), .cfg_flat(cfg_flat),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_reject(wr_reject),
    .fast_go(fast_go), .trig_go(trig_go)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  chip;
    logic [5:0]  addr;
    logic [15:0] data;
    logic        ev;
    logic [15:0] ed;
    logic        er;
    logic        ef;
    logic        et;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 3'd0, 6'd0,  16'h0000, 1'b1, 16'hC300, 1'b0, 1'b0, 1'b0}, // R1 R8
    '{2'd1, 3'd0, 6'd5,  16'h0000, 1'b1, 16'hC314, 1'b0, 1'b0, 1'b0}, // R8
    '{2'd0, 3'd0, 6'd5,  16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd1, 3'd0, 6'd5,  16'h0000, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd0, 3'd0, 6'd3,  16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd1, 3'd0, 6'd3,  16'h0000, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd0, 3'd0, 6'd40, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R4
    '{2'd1, 3'd0, 6'd40, 16'h0000, 1'b1, 16'hE004, 1'b0, 1'b0, 1'b0}, // R6
    '{2'd0, 3'd2, 6'd6,  16'h5555, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R5
    '{2'd1, 3'd0, 6'd6,  16'h0000, 1'b1, 16'hC318, 1'b0, 1'b0, 1'b0}, // R5
    '{2'd1, 3'd1, 6'd6,  16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R5
    '{2'd0, 3'd0, 6'd35, 16'h00F0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd1, 3'd0, 6'd35, 16'h0000, 1'b1, 16'h0F00, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd0, 3'd0, 6'd36, 16'h9999, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R4
    '{2'd1, 3'd0, 6'd36, 16'h0000, 1'b1, 16'hE000, 1'b0, 1'b0, 1'b0}, // R6
    '{2'd1, 3'd0, 6'd63, 16'h0000, 1'b1, 16'hE01B, 1'b0, 1'b0, 1'b0}, // R6
    '{2'd0, 3'd0, 6'd10, 16'hA5C3, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd1, 3'd0, 6'd10, 16'h0000, 1'b1, 16'hC3A5, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd0, 3'd0, 6'd4,  16'h0F0F, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd1, 3'd0, 6'd4,  16'h0000, 1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd2, 3'd7, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0}, // R7
    '{2'd3, 3'd5, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1}  // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one command for one cycle; on return the answer is visible.
  task automatic issue(input logic [1:0] k, input logic [2:0] c,
                       input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_chip = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [15:0] cfg_word(input int i);
    return cfg_flat[i*16 +: 16];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check("R8 rd_valid", 32'(rd_valid), 0);
    check("R8 wr_reject", 32'(wr_reject), 0);
    check("R8 go", 32'({fast_go, trig_go}), 0);
    check("R8 word0", 32'(cfg_word(0)), 32'h0000C300);
    check("R8 word1", 32'(cfg_word(1)), 32'h0000C304);
    check("R8 word35", 32'(cfg_word(35)), 32'h0000C38C);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].kind, TBL[i].chip, TBL[i].addr, TBL[i].data);
      check($sformatf("R6 vec%0d rd_valid", i), 32'(rd_valid), 32'(TBL[i].ev));
      if (TBL[i].ev) check($sformatf("R2 vec%0d rd_data", i), 32'(rd_data), 32'(TBL[i].ed));
      check($sformatf("R4 vec%0d wr_reject", i), 32'(wr_reject), 32'(TBL[i].er));
      check($sformatf("R7 vec%0d fast_go", i), 32'(fast_go), 32'(TBL[i].ef));
      check($sformatf("R7 vec%0d trig_go", i), 32'(trig_go), 32'(TBL[i].et));
    end

    // R9: flat bus shows stored words
    check("R9 word5", 32'(cfg_word(5)), 32'h00001234);
    check("R9 word10", 32'(cfg_word(10)), 32'h0000C3A5);
    check("R9 word6 untouched", 32'(cfg_word(6)), 32'h0000C318);

    // R4: pulse lasts one cycle only
    @(negedge clk);
    check("R4 pulse ends", 32'(wr_reject), 0);

    // R4: refused write to addr 50 leaves every word unchanged
    begin
      logic [575:0] snap;
      snap = cfg_flat;
      issue(2'd0, 3'd0, 6'd50, 16'hDEAD);
      check("R4 reject", 32'(wr_reject), 1);
      check("R4 unchanged", 32'(cfg_flat == snap), 1);
    end

    // R4 R5: back-to-back refused writes give one pulse each
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_chip = 3'd4; cmd_addr = 6'd2; cmd_data = 16'h1111;
    @(negedge clk);
    check("R5 pulse a", 32'(wr_reject), 1);
    cmd_addr = 6'd60;
    cmd_chip = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R4 pulse b", 32'(wr_reject), 1);
    @(negedge clk);
    check("R4 pulse over", 32'(wr_reject), 0);
    check("R5 word2 unchanged", 32'(cfg_word(2)), 32'h0000C308);

    // R1: non-zero strap identity
    strap_id = 3'b101;
    issue(2'd0, 3'd5, 6'd7, 16'h7777);
    check("R1 strap write ok", 32'(wr_reject), 0);
    check("R1 strap stored", 32'(cfg_word(7)), 32'h00007777);
    issue(2'd1, 3'd5, 6'd7, 16'h0000);
    check("R1 strap read", 32'({rd_valid, rd_data}), 32'h00017777);
    issue(2'd0, 3'd0, 6'd7, 16'h0000);
    check("R1 old id refused", 32'(wr_reject), 1);
    check("R1 word7 kept", 32'(cfg_word(7)), 32'h00007777);
    issue(2'd1, 3'd0, 6'd7, 16'h0000);
    check("R1 old id read silent", 32'(rd_valid), 0);
    strap_id = 3'b000;

    // R8: synchronous reset restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 word5 restored", 32'(cfg_word(5)), 32'h0000C314);
    check("R8 word7 restored", 32'(cfg_word(7)), 32'h0000C31C);
    check("R8 word35 restored", 32'(cfg_word(35)), 32'h0000C38C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule